// File: doc/BRIEF.md
# Lane-Banked Register File with One-Hot Addressing

This block holds 128 registers split into four lanes, with register `r` stored in lane `r % 4` at row `r / 4`. Addressing uses no binary indices. Every write port and every read requester presents a 128-bit vector with one bit set for the register it wants.

Each lane has its own write port and its own read bus. A write port only stores into registers of its own lane, so no write crossbar is needed. Read requesters may target any lane. Each lane's read multiplexer serves one requester per cycle, picked by a round-robin arbiter. A requester that loses keeps its vector asserted and retries on the next cycle. A requester sees its grant in the same cycle and its data, with a valid flag, one cycle later.

Top module: `rf_banked`

## Requirements
- R1: Register `r` (0..127) lives in lane `r % 4`. Bit `r` of a 128-bit vector selects register `r`. Bits `[128*p +: 128]` of `wrVec` belong to write port `p`, and bits `[128*k +: 128]` of `rdVec` belong to requester `k`.
- R2: Write port `p` with exactly one bit `r` set, where `r % 4 == p`, stores its data word `wrData[32*p +: 32]` into register `r` at the clock edge. If instead `r % 4 != p`, the port raises `wrErr[p]` in the same cycle and nothing is written.
- R3: A write vector with two or more bits set raises `wrErr` for that port in the same cycle, and no register changes.
- R4: A read vector with two or more bits set raises `rdErr` for that requester in the same cycle. No grant is issued and no valid follows.
- R5: A read granted in a cycle is answered on the next cycle with `rdValid[k]` high and `rdData[32*k +: 32]` holding the register's contents.
- R6: Requesters targeting different lanes are all granted in the same cycle. At most one requester per lane is granted per cycle.
- R7: Each lane arbitrates round-robin. After reset, requester 0 has top priority. After requester `w` wins, priority starts at `w+1` (wrapping), so `w` ranks last.
- R8: When a register is written and read in the same cycle, the read returns the value it held before the write.
- R9: Reset clears all registers to zero and clears `rdValid`.
- R10: An all-zero vector neither writes nor requests a read, and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrVec | input | 512 | One-hot register select for each of the 4 lane write ports |
| wrData | input | 128 | 32-bit write data for each lane write port |
| wrErr | output | 4 | Per-port rejected write (several bits set, or register outside the lane) |
| rdVec | input | 512 | One-hot register select for each of the 4 read requesters |
| rdGnt | output | 4 | Per-requester read grant, same cycle |
| rdErr | output | 4 | Per-requester malformed read vector |
| rdValid | output | 4 | Per-requester read data valid, the cycle after a grant |
| rdData | output | 128 | 32-bit read data for each requester |

## Verification
The arbitration assertions assume that a requester which loses keeps its vector unchanged, and that no read vector is presented while reset is asserted. The bench drives each vector only between falling edges, and it holds a contending request until the grant arrives. The read-after-grant property relies on reset being released at a falling edge, with all vectors at zero. The lane sweeps write and read every register. The contention run re-requests from the last winner so that the rotation of priority becomes visible at the grant port.

// File: rtl/rf_bank_pkg.sv
package rf_bank_pkg;
  localparam int REGS    = 128;
  localparam int BANKS   = 4;
  localparam int READERS = 4;
  localparam int DATA_W  = 32;

  localparam int ROWS   = REGS / BANKS;
  localparam int REG_W  = $clog2(REGS);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = REG_W - BANK_W;

  typedef struct packed {
    logic             wrEn;
    logic [ROW_W-1:0] wrRow;
    logic             rdEn;
    logic [ROW_W-1:0] rdRow;
  } bankStb_t;

  typedef struct packed {
    logic              gnt;
    logic [BANK_W-1:0] bank;
  } rdStb_t;

  function automatic logic [REG_W-1:0] lowestSet(input logic [REGS-1:0] v);
    logic [REG_W-1:0] idx;
    idx = '0;
    for (int i = REGS - 1; i >= 0; i--) begin
      if (v[i]) idx = REG_W'(i);
    end
    return idx;
  endfunction

  function automatic logic severalSet(input logic [REGS-1:0] v);
    return (v & (v - 1'b1)) != '0;
  endfunction
endpackage

// File: rtl/rf_rr_arb.sv
module rf_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] win;
  logic          found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int off = 0; off < N; off++) begin
      int j;
      j = int'(ptr) + off;
      if (j >= N) j = j - N;
      if (!found && req[j]) begin
        gnt[j] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    win = '0;
    for (int k = 0; k < N; k++) begin
      if (gnt[k]) win = PW'(k);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (|gnt) ptr <= (int'(win) == N - 1) ? '0 : win + 1'b1;
  end

  // R6
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(gnt));
  // R6
  gnt_has_req_chk: assert property (@(posedge clk) disable iff (!rstN) (gnt & ~req) == '0);
  // R7
  rr_rotate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(|gnt) && ((req & ~$past(gnt)) != '0)) |-> ((gnt & $past(gnt)) == '0));
endmodule

// File: rtl/rf_bank_ctrl.sv
module rf_bank_ctrl
  import rf_bank_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [BANKS-1:0][REGS-1:0]      wrVec,
  input  logic [READERS-1:0][REGS-1:0]    rdVec,
  output logic [BANKS-1:0]                wrErr,
  output logic [READERS-1:0]              rdErr,
  output logic [READERS-1:0]              rdGnt,
  output bankStb_t [BANKS-1:0]            bankStb,
  output rdStb_t [READERS-1:0]            rdStb
);
  logic [READERS-1:0][REG_W-1:0]   rIdx;
  logic [READERS-1:0]              rOk;
  logic [READERS-1:0][BANK_W-1:0]  tgt;
  logic [BANKS-1:0][READERS-1:0]   gntMat;

  // decode of each read request
  for (genvar k = 0; k < READERS; k++) begin : g_rd
    logic any, multi;
    assign any     = |rdVec[k];
    assign multi   = severalSet(rdVec[k]);
    assign rIdx[k] = lowestSet(rdVec[k]);
    assign rOk[k]  = any && !multi;
    assign rdErr[k] = any && multi;
    assign tgt[k]  = rIdx[k][BANK_W-1:0];
    assign rdGnt[k] = gntMat[tgt[k]][k];
    assign rdStb[k] = '{gnt: gntMat[tgt[k]][k], bank: tgt[k]};
  end

  // per-lane write decode and read arbitration
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [REG_W-1:0]   wIdx;
    logic               wAny, wMulti, laneOk;
    logic [READERS-1:0] req, gnt;
    logic [ROW_W-1:0]   rowSel;

    assign wIdx   = lowestSet(wrVec[b]);
    assign wAny   = |wrVec[b];
    assign wMulti = severalSet(wrVec[b]);
    assign laneOk = wIdx[BANK_W-1:0] == BANK_W'(b);
    assign wrErr[b] = wAny && (wMulti || !laneOk);

    for (genvar k = 0; k < READERS; k++) begin : g_req
      assign req[k] = rOk[k] && (tgt[k] == BANK_W'(b));
    end

    rf_rr_arb #(.N(READERS)) u_arb (
      .clk  (clk),
      .rstN (rstN),
      .req  (req),
      .gnt  (gnt)
    );
    assign gntMat[b] = gnt;

    always_comb begin
      rowSel = '0;
      for (int k = 0; k < READERS; k++) begin
        if (gnt[k]) rowSel = rIdx[k][REG_W-1:BANK_W];
      end
    end

    assign bankStb[b] = '{wrEn:  wAny && !wMulti && laneOk,
                          wrRow: wIdx[REG_W-1:BANK_W],
                          rdEn:  |gnt,
                          rdRow: rowSel};
  end
endmodule

// File: rtl/rf_bank_dp.sv
module rf_bank_dp
  import rf_bank_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [BANKS-1:0][DATA_W-1:0]     wrData,
  input  bankStb_t [BANKS-1:0]             bankStb,
  input  rdStb_t [READERS-1:0]             rdStb,
  output logic [READERS-1:0]               rdValid,
  output logic [READERS-1:0][DATA_W-1:0]   rdData
);
  logic [BANKS-1:0][DATA_W-1:0] bankBus;

  for (genvar b = 0; b < BANKS; b++) begin : g_lane
    logic [DATA_W-1:0] mem [ROWS];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < ROWS; i++) mem[i] <= '0;
      end else if (bankStb[b].wrEn) begin
        mem[bankStb[b].wrRow] <= wrData[b];
      end
    end

    // lane read bus, sampled before this edge's write lands
    assign bankBus[b] = mem[bankStb[b].rdRow];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= '0;
      rdData  <= '0;
    end else begin
      for (int k = 0; k < READERS; k++) begin
        rdValid[k] <= rdStb[k].gnt;
        if (rdStb[k].gnt) rdData[k] <= bankBus[rdStb[k].bank];
      end
    end
  end
endmodule

// File: rtl/rf_banked.sv
module rf_banked
  import rf_bank_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [BANKS*REGS-1:0]       wrVec,
  input  logic [BANKS*DATA_W-1:0]     wrData,
  output logic [BANKS-1:0]            wrErr,
  input  logic [READERS*REGS-1:0]     rdVec,
  output logic [READERS-1:0]          rdGnt,
  output logic [READERS-1:0]          rdErr,
  output logic [READERS-1:0]          rdValid,
  output logic [READERS*DATA_W-1:0]   rdData
);
  logic [BANKS-1:0][REGS-1:0]        wrVecA;
  logic [READERS-1:0][REGS-1:0]      rdVecA;
  logic [BANKS-1:0][DATA_W-1:0]      wrDataA;
  logic [READERS-1:0][DATA_W-1:0]    rdDataA;
  bankStb_t [BANKS-1:0]              bankStb;
  rdStb_t [READERS-1:0]              rdStb;

  assign wrVecA  = wrVec;
  assign rdVecA  = rdVec;
  assign wrDataA = wrData;
  assign rdData  = rdDataA;

  rf_bank_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrVec   (wrVecA),
    .rdVec   (rdVecA),
    .wrErr   (wrErr),
    .rdErr   (rdErr),
    .rdGnt   (rdGnt),
    .bankStb (bankStb),
    .rdStb   (rdStb)
  );

  rf_bank_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wrData  (wrDataA),
    .bankStb (bankStb),
    .rdStb   (rdStb),
    .rdValid (rdValid),
    .rdData  (rdDataA)
  );

  // R4
  bad_read_no_gnt_chk: assert property (@(posedge clk) disable iff (!rstN) (rdErr & rdGnt) == '0);
  // R5
  valid_after_gnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (rdValid == $past(rdGnt)));
endmodule

// File: tb/rf_banked_bench.sv
`timescale 1ns/1ps
module rf_banked_bench;
  import rf_bank_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [BANKS*REGS-1:0]     wrVec = '0;
  logic [BANKS*DATA_W-1:0]   wrData = '0;
  logic [BANKS-1:0]          wrErr;
  logic [READERS*REGS-1:0]   rdVec = '0;
  logic [READERS-1:0]        rdGnt, rdErr, rdValid;
  logic [READERS*DATA_W-1:0] rdData;

  int vecs = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rf_banked u_rf_banked (.*);

  function automatic logic [DATA_W-1:0] pat(int r);
    return 32'hC0DE0000 ^ (32'(r) * 32'h00010101);
  endfunction

  function automatic logic [REGS-1:0] oh(int r);
    return {{(REGS-1){1'b0}}, 1'b1} << r;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clearAll();
    wrVec = '0; wrData = '0; rdVec = '0;
  endtask

  task automatic doReset();
    clearAll();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic readOne(int k, int r, logic [DATA_W-1:0] exp, string req);
    rdVec[k*REGS +: REGS] = oh(r);
    #1 chk(rdGnt[k] === 1'b1, req, 64'(rdGnt), 64'(1 << k));
    @(negedge clk);
    rdVec = '0;
    chk(rdValid[k] === 1'b1 && rdData[k*DATA_W +: DATA_W] === exp, req,
        64'(rdData[k*DATA_W +: DATA_W]), 64'(exp));
  endtask

  initial begin
    doReset();
    // R9: cleared state
    chk(rdValid === '0, "R9", 64'(rdValid), 0);
    for (int r = 0; r < REGS; r++) readOne(r % READERS, r, '0, "R9");

    // R1 R2: fill every register, one per lane per cycle
    for (int row = 0; row < ROWS; row++) begin
      for (int b = 0; b < BANKS; b++) begin
        wrVec[b*REGS +: REGS] = oh(row*BANKS + b);
        wrData[b*DATA_W +: DATA_W] = pat(row*BANKS + b);
      end
      #1 chk(wrErr === '0, "R1", 64'(wrErr), 0);
      @(negedge clk);
      clearAll();
    end

    // R5 R6 R1: all requesters on distinct lanes at once
    for (int row = 0; row < ROWS; row++) begin
      for (int k = 0; k < READERS; k++)
        rdVec[k*REGS +: REGS] = oh(row*BANKS + (k + row) % BANKS);
      #1 chk(rdGnt === '1, "R6", 64'(rdGnt), 64'hF);
      @(negedge clk);
      rdVec = '0;
      for (int k = 0; k < READERS; k++) begin
        int r;
        r = row*BANKS + (k + row) % BANKS;
        chk(rdValid[k] === 1'b1 && rdData[k*DATA_W +: DATA_W] === pat(r), "R5",
            64'(rdData[k*DATA_W +: DATA_W]), 64'(pat(r)));
      end
    end

    // R2: wrong-lane write rejected
    wrVec[0 +: REGS] = oh(5);
    wrData[0 +: DATA_W] = 32'h00000BAD;
    #1 chk(wrErr === 4'b0001, "R2", 64'(wrErr), 1);
    @(negedge clk);
    clearAll();
    readOne(0, 5, pat(5), "R2");
    // R2: in-lane write lands
    wrVec[1*REGS +: REGS] = oh(13);
    wrData[1*DATA_W +: DATA_W] = 32'h13131313;
    #1 chk(wrErr === '0, "R2", 64'(wrErr), 0);
    @(negedge clk);
    clearAll();
    readOne(3, 13, 32'h13131313, "R2");

    // R3: several bits in a write vector
    wrVec[1*REGS +: REGS] = oh(1) | oh(5);
    wrData[1*DATA_W +: DATA_W] = 32'hFFFFFFFF;
    #1 chk(wrErr === 4'b0010, "R3", 64'(wrErr), 2);
    @(negedge clk);
    clearAll();
    readOne(1, 1, pat(1), "R3");
    readOne(1, 5, pat(5), "R3");

    // R4: several bits in a read vector
    rdVec[3*REGS +: REGS] = oh(0) | oh(64);
    #1 chk(rdErr === 4'b1000 && rdGnt === '0, "R4", 64'({rdErr, rdGnt}), 64'h80);
    @(negedge clk);
    rdVec = '0;
    chk(rdValid === '0, "R4", 64'(rdValid), 0);

    // R8: same-cycle write and read of register 9
    rdVec[2*REGS +: REGS] = oh(9);
    wrVec[1*REGS +: REGS] = oh(9);
    wrData[1*DATA_W +: DATA_W] = 32'hDEADBEEF;
    @(negedge clk);
    clearAll();
    chk(rdValid[2] === 1'b1 && rdData[2*DATA_W +: DATA_W] === pat(9), "R8",
        64'(rdData[2*DATA_W +: DATA_W]), 64'(pat(9)));
    readOne(2, 9, 32'hDEADBEEF, "R8");

    // R10: all-zero vectors
    clearAll();
    #1 chk(wrErr === '0 && rdErr === '0 && rdGnt === '0, "R10", 64'({wrErr, rdErr, rdGnt}), 0);
    @(negedge clk);
    chk(rdValid === '0, "R10", 64'(rdValid), 0);

    // R7: contention on lane 2 after a fresh reset
    doReset();
    for (int k = 0; k <= READERS; k++) begin
      wrVec[2*REGS +: REGS] = oh(2 + 4*k);
      wrData[2*DATA_W +: DATA_W] = pat(2 + 4*k);
      @(negedge clk);
    end
    clearAll();
    begin
      int regOf [READERS];
      bit pend [READERS];
      int ptr;
      bit reArmed;
      ptr = 0;
      reArmed = 0;
      for (int k = 0; k < READERS; k++) begin
        regOf[k] = 2 + 4*k;
        pend[k] = 1;
      end
      for (int c = 0; c <= READERS; c++) begin
        int win;
        rdVec = '0;
        for (int k = 0; k < READERS; k++)
          if (pend[k]) rdVec[k*REGS +: REGS] = oh(regOf[k]);
        win = -1;
        for (int off = 0; off < READERS; off++) begin
          int j;
          j = (ptr + off) % READERS;
          if (win < 0 && pend[j]) win = j;
        end
        #1 chk(rdGnt === 4'(1 << win), "R7", 64'(rdGnt), 64'(1 << win));
        @(negedge clk);
        chk(rdValid === 4'(1 << win) && rdData[win*DATA_W +: DATA_W] === pat(regOf[win]), "R7",
            64'(rdData[win*DATA_W +: DATA_W]), 64'(pat(regOf[win])));
        ptr = (win + 1) % READERS;
        if (win == 0 && !reArmed) begin
          regOf[0] = 2 + 4*READERS;
          reArmed = 1;
        end else pend[win] = 0;
      end
      rdVec = '0;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule